// File: doc/BRIEF.md
# Video Memory Serial Output Port

This block models a small dual-ported video memory. A random-access port gives single-word reads and writes to a row-by-column storage array. The same port can also issue a line-load command. That command copies one complete row into a private line buffer in a single core clock cycle. Each row holds one horizontal display line.

A second, read-only port streams the loaded line out one word at a time. It is paced by a free-running shift clock that is asynchronous to the core clock. That clock is brought into the core domain through a flop synchroniser followed by an edge detector. The random-access port stays free for drawing traffic while the line streams out. The line buffer is isolated from later writes to the array, so a line keeps the contents it had when it was loaded. After the last column the stream wraps to column zero of the same line. A flag marks the cycle span in which the last column is on the output.

Top module: `vram_serial_port`

## Requirements
- R1: While reset is asserted and right after it is released, `ser_data` is 0, `line_end` is 0 and `ra_rdata` is 0. Every array word is 0.
- R2: On a clock edge with `ra_we` high, `ra_wdata` is written to the word at (`ra_row`, `ra_col`). `ra_rdata` presents, one edge later, the word stored at the address sampled on that edge. If a write to the same address falls on the same edge, the read returns the old value.
- R3: On a clock edge with `xfer_req` high, all columns of row `ra_row` are copied into the line buffer. From the next cycle, `ser_data` shows column 0 of that row.
- R4: Each rising edge of `sclk` advances the serial output by exactly one column, in increasing column order. The new word appears after the third core clock edge that follows the rise. Holding `sclk` high, or a low level, never advances the output again.
- R5: `line_end` is 1 exactly while column COLS-1 is on `ser_data`. An advance from that column wraps to column 0 of the same loaded line, and `line_end` then drops.
- R6: Writes to the array after a line load, or on the same edge as the load, do not change the words held in the line buffer. A write to the loaded row on the load edge is not in the buffer, but it is in the array.
- R7: When a line load and a shift advance fall on the same core clock edge, the load wins. The output shows column 0 of the new row, and the advance is discarded.
- R8: Random-access reads and writes return the same results whether or not the serial port is streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_row | input | ROW_W | Row address for access and line load |
| ra_col | input | COL_W | Column address for access |
| ra_wdata | input | DATA_W | Write data |
| ra_we | input | 1 | Write enable |
| ra_rdata | output | DATA_W | Registered read data |
| xfer_req | input | 1 | Copy row `ra_row` into the line buffer |
| sclk | input | 1 | Asynchronous shift clock |
| ser_data | output | DATA_W | Current serial output word |
| line_end | output | 1 | High while the last column is shown |

## Verification
Two events can land on the same core clock edge: a line load and the synchronised shift advance. Another pair is a line load and an array write to the loaded row. The bench times a line-load request so that it is sampled on the very edge where the edge detector fires. It then checks that column 0 of the new row is shown and stays shown, which proves the advance was dropped. A separate case writes the row being loaded on the load edge. It then checks that the stream carries the old word while a read-back returns the new one.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
   typedef enum logic {
      VSP_OUT_COMB = 1'b0,
      VSP_OUT_REG  = 1'b1
   } vsp_out_e;

   localparam int unsigned VSP_MIN_SYNC = 2;
endpackage

// File: rtl/vsp_edge_sync.sv
module vsp_edge_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);
   if (STAGES < vsp_pkg::VSP_MIN_SYNC) begin : g_bad_stages
      $error("vsp_edge_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   if (RISING) begin : g_rise
      assign pulse = sync_q[STAGES-1] & ~last_q;
   end else begin : g_fall
      assign pulse = ~sync_q[STAGES-1] & last_q;
   end
endmodule

// File: rtl/vsp_store.sv
module vsp_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ROW_W  = 2,
   parameter int unsigned COL_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ROW_W-1:0]             row,
   input  logic [COL_W-1:0]             col,
   input  logic [DATA_W-1:0]            wdata,
   input  logic                         we,
   output logic [DATA_W-1:0]            rdata,
   output logic [(DATA_W<<COL_W)-1:0]   row_flat
);
   localparam int unsigned ROWS = 1 << ROW_W;
   localparam int unsigned COLS = 1 << COL_W;

   logic [DATA_W-1:0] mem_q [ROWS][COLS];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
               mem_q[r][c] <= '0;
            end
         end
         rd_q <= '0;
      end else begin
         rd_q <= mem_q[row][col];
         if (we) begin
            mem_q[row][col] <= wdata;
         end
      end
   end

   assign rdata = rd_q;

   for (genvar c = 0; c < COLS; c++) begin : g_pack
      assign row_flat[c*DATA_W +: DATA_W] = mem_q[row][c];
   end
endmodule

// File: rtl/vsp_line_shifter.sv
module vsp_line_shifter #(
   parameter int unsigned      DATA_W   = 8,
   parameter int unsigned      COL_W    = 3,
   parameter vsp_pkg::vsp_out_e OUT_MODE = vsp_pkg::VSP_OUT_COMB
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [(DATA_W<<COL_W)-1:0]   row_in,
   input  logic                         step,
   output logic [DATA_W-1:0]            data_out,
   output logic                         line_last,
   output logic [COL_W-1:0]             ptr,
   output logic [(DATA_W<<COL_W)-1:0]   line_bits
);
   localparam int unsigned         COLS  = 1 << COL_W;
   localparam int unsigned         LBITS = DATA_W * COLS;
   localparam logic [COL_W-1:0]    LAST  = COL_W'(COLS - 1);

   logic [LBITS-1:0] sh_q, sh_nx;
   logic [COL_W-1:0] ptr_q, ptr_nx;

   function automatic logic [DATA_W-1:0] pick(input logic [LBITS-1:0] bits,
                                              input logic [COL_W-1:0] idx);
      logic [DATA_W-1:0] w;
      w = '0;
      for (int c = 0; c < COLS; c++) begin
         if (idx == COL_W'(c)) w = bits[c*DATA_W +: DATA_W];
      end
      return w;
   endfunction

   always_comb begin
      sh_nx  = sh_q;
      ptr_nx = ptr_q;
      if (load) begin
         sh_nx  = row_in;
         ptr_nx = '0;
      end else if (step) begin
         ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         ptr_q <= '0;
      end else begin
         sh_q  <= sh_nx;
         ptr_q <= ptr_nx;
      end
   end

   if (OUT_MODE == vsp_pkg::VSP_OUT_REG) begin : g_out_reg
      logic [DATA_W-1:0] dout_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout_q <= '0;
         else        dout_q <= pick(sh_nx, ptr_nx);
      end
      assign data_out = dout_q;
   end else begin : g_out_comb
      assign data_out = pick(sh_q, ptr_q);
   end

   assign line_last = (ptr_q == LAST);
   assign ptr       = ptr_q;
   assign line_bits = sh_q;
endmodule

// File: rtl/vram_serial_port.sv
module vram_serial_port #(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ROW_W       = 2,
   parameter int unsigned       COL_W       = 3,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter vsp_pkg::vsp_out_e OUT_MODE    = vsp_pkg::VSP_OUT_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  ra_row,
   input  logic [COL_W-1:0]  ra_col,
   input  logic [DATA_W-1:0] ra_wdata,
   input  logic              ra_we,
   output logic [DATA_W-1:0] ra_rdata,
   input  logic              xfer_req,
   input  logic              sclk,
   output logic [DATA_W-1:0] ser_data,
   output logic              line_end
);
   localparam int unsigned COLS  = 1 << COL_W;
   localparam int unsigned LBITS = DATA_W * COLS;

   if (DATA_W < 1) begin : g_bad_data
      $error("vram_serial_port: DATA_W must be at least 1");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("vram_serial_port: ROW_W must be at least 1");
   end
   if (COL_W < 1) begin : g_bad_col
      $error("vram_serial_port: COL_W must be at least 1");
   end
   if (SYNC_STAGES < vsp_pkg::VSP_MIN_SYNC) begin : g_bad_sync
      $error("vram_serial_port: SYNC_STAGES too small");
   end

   logic             shift_pulse;
   logic [LBITS-1:0] row_flat;
   logic [COL_W-1:0] sh_ptr;
   logic [LBITS-1:0] sh_bits;

   vsp_edge_sync #(
      .STAGES (SYNC_STAGES),
      .RISING (1'b1)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sclk),
      .pulse    (shift_pulse)
   );

   vsp_store #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .row      (ra_row),
      .col      (ra_col),
      .wdata    (ra_wdata),
      .we       (ra_we),
      .rdata    (ra_rdata),
      .row_flat (row_flat)
   );

   vsp_line_shifter #(
      .DATA_W   (DATA_W),
      .COL_W    (COL_W),
      .OUT_MODE (OUT_MODE)
   ) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (xfer_req),
      .row_in    (row_flat),
      .step      (shift_pulse),
      .data_out  (ser_data),
      .line_last (line_end),
      .ptr       (sh_ptr),
      .line_bits (sh_bits)
   );
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned COL_W  = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       xfer_req,
   input logic                       shift_pulse,
   input logic [COL_W-1:0]           ptr,
   input logic [(DATA_W<<COL_W)-1:0] line_bits,
   input logic [DATA_W-1:0]          ser_data,
   input logic                       line_end
);
   // R3: a load restarts at column 0
   a_r3_load_col0: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> (ptr == '0));

   // R7: load beats a coincident advance
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && shift_pulse) |=> (ptr == '0));

   // R4: one column per advance
   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_pulse && !xfer_req && !line_end) |=> (ptr == $past(ptr) + 1'b1));

   // R4: no advance without a pulse
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_pulse && !xfer_req) |=> ($stable(ptr) && $stable(ser_data)));

   // R4: each sclk edge gives a single-cycle pulse
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> !shift_pulse);

   // R5: advance from the last column wraps to 0
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_pulse && !xfer_req && line_end) |=> (ptr == '0 && !line_end));

   // R6: buffer contents change only on a load
   a_r6_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req |=> $stable(line_bits));
endmodule

bind vram_serial_port vsp_checker #(
   .DATA_W (DATA_W),
   .COL_W  (COL_W)
) i_vsp_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_req    (xfer_req),
   .shift_pulse (shift_pulse),
   .ptr         (sh_ptr),
   .line_bits   (sh_bits),
   .ser_data    (ser_data),
   .line_end    (line_end)
);

// File: tb/test_vram_serial_port.sv
`timescale 1ns/1ps
module test_vram_serial_port;
   localparam int DW = 8;
   localparam int RW = 2;
   localparam int CW = 3;
   localparam int NR = 1 << RW;
   localparam int NC = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] ra_row = '0;
   logic [CW-1:0] ra_col = '0;
   logic [DW-1:0] ra_wdata = '0;
   logic          ra_we = 1'b0;
   logic [DW-1:0] ra_rdata;
   logic          xfer_req = 1'b0;
   logic          sclk = 1'b0;
   logic [DW-1:0] ser_data;
   logic          line_end;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vram_serial_port #(.DATA_W(DW), .ROW_W(RW), .COL_W(CW)) i_vram_serial_port (
      .clk(clk), .rst_n(rst_n), .ra_row(ra_row), .ra_col(ra_col),
      .ra_wdata(ra_wdata), .ra_we(ra_we), .ra_rdata(ra_rdata),
      .xfer_req(xfer_req), .sclk(sclk), .ser_data(ser_data), .line_end(line_end)
   );

   function automatic int pat(int r, int c);
      return (r * 37 + c * 11 + 5) & 255;
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   // behavioural reference model, updated on every core edge
   int m_mem [NR][NC];
   int m_sh  [NC];
   int m_ptr;
   int m_rd;
   int sq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[r, c]) m_mem[r][c] = 0;
         foreach (m_sh[c]) m_sh[c] = 0;
         m_ptr = 0;
         m_rd  = 0;
         sq = '{0, 0, 0};
      end else begin
         int rd_new;
         bit adv;
         // sq[0] newest sample; rise seen two samples back advances now
         adv = (sq[1] == 1) && (sq[2] == 0);
         sq.push_front(int'(sclk));
         void'(sq.pop_back());
         rd_new = m_mem[ra_row][ra_col];
         if (xfer_req) begin
            for (int c = 0; c < NC; c++) m_sh[c] = m_mem[ra_row][c];
            m_ptr = 0;
         end else if (adv) begin
            m_ptr = (m_ptr + 1) % NC;
         end
         if (ra_we) m_mem[ra_row][ra_col] = int'(ra_wdata);
         m_rd = rd_new;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 model rdata", 32'(ra_rdata), 32'(m_rd));
         chk("R4 model ser_data", 32'(ser_data), 32'(m_sh[m_ptr]));
         chk("R5 model line_end", 32'(line_end), 32'(m_ptr == NC - 1));
      end
   end

   task automatic wr(int r, int c, int d);
      ra_row = RW'(r); ra_col = CW'(c); ra_wdata = DW'(d); ra_we = 1'b1;
      @(negedge clk);
      ra_we = 1'b0;
   endtask

   task automatic load(int r);
      ra_row = RW'(r); xfer_req = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0;
   endtask

   task automatic shift_one();
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ser_data in reset", 32'(ser_data), 0);
      chk("R1 rdata in reset", 32'(ra_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ser_data", 32'(ser_data), 0);
      chk("R1 line_end", 32'(line_end), 0);
      chk("R1 rdata", 32'(ra_rdata), 0);

      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) wr(r, c, pat(r, c));

      // R2 read back
      ra_row = 2'd2; ra_col = 3'd3;
      @(negedge clk);
      chk("R2 read", 32'(ra_rdata), 32'(pat(2, 3)));
      // R2 same-address read and write: old value first
      ra_row = 2'd1; ra_col = 3'd4; ra_wdata = 8'h3C; ra_we = 1'b1;
      @(negedge clk);
      ra_we = 1'b0;
      chk("R2 read-before-write", 32'(ra_rdata), 32'(pat(1, 4)));
      @(negedge clk);
      chk("R2 new value", 32'(ra_rdata), 32'h3C);

      // R3 line load
      load(2);
      chk("R3 col0", 32'(ser_data), 32'(pat(2, 0)));
      chk("R3 line_end low", 32'(line_end), 0);

      // R4 stepping
      for (int i = 1; i <= 3; i++) begin
         shift_one();
         chk("R4 step", 32'(ser_data), 32'(pat(2, i)));
      end
      // R4 level held high advances once
      sclk = 1'b1;
      repeat (20) @(negedge clk);
      chk("R4 held high", 32'(ser_data), 32'(pat(2, 4)));
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4 no advance on fall", 32'(ser_data), 32'(pat(2, 4)));

      // R6 write after load does not reach buffer
      wr(2, 5, 8'hEE);
      shift_one();
      chk("R6 buffer isolated", 32'(ser_data), 32'(pat(2, 5)));

      // R5 end of line and wrap
      shift_one();
      chk("R5 col6 flag", 32'(line_end), 0);
      shift_one();
      chk("R5 last col data", 32'(ser_data), 32'(pat(2, 7)));
      chk("R5 last col flag", 32'(line_end), 1);
      shift_one();
      chk("R5 wrap data", 32'(ser_data), 32'(pat(2, 0)));
      chk("R5 wrap flag", 32'(line_end), 0);

      // R6 write on the load edge to the loaded row
      ra_row = 2'd3; ra_col = 3'd0; ra_wdata = 8'h77; ra_we = 1'b1; xfer_req = 1'b1;
      @(negedge clk);
      ra_we = 1'b0; xfer_req = 1'b0;
      chk("R6 load-edge write excluded", 32'(ser_data), 32'(pat(3, 0)));
      @(negedge clk);
      chk("R6 array holds write", 32'(ra_rdata), 32'h77);

      // R8 random access while a shift is in flight
      sclk = 1'b1; ra_row = 2'd0; ra_col = 3'd6;
      @(negedge clk);
      chk("R8 read during stream", 32'(ra_rdata), 32'(pat(0, 6)));
      wr(0, 1, 8'h5A);
      ra_col = 3'd1;
      @(negedge clk);
      chk("R8 write during stream", 32'(ra_rdata), 32'h5A);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 stream unaffected", 32'(ser_data), 32'(pat(3, 1)));
      shift_one();

      // R7 load coincides with the advance edge
      sclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ra_row = 2'd1; xfer_req = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0;
      chk("R7 load wins", 32'(ser_data), 32'(pat(1, 0)));
      repeat (6) @(negedge clk);
      chk("R7 advance dropped", 32'(ser_data), 32'(pat(1, 0)));
      sclk = 1'b0;
      repeat (4) @(negedge clk);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired got 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule